// File: doc/BRIEF.md
# PCIe Root Interrupt Aggregator

This block gathers every interrupt-worthy event seen on the link side of a PCIe root port and turns them into one level-sensitive interrupt line for the CPU. Legacy INTx assert and deassert messages, message-signalled interrupts (MSI) and two link-management events (a power-state change and a flush) each set a bit in a status register. Every status register clears by writing 1 to a bit, and each one has a companion mask register in which a 1 blocks that source from propagating.

The hierarchy has two levels. The MSI vector register records which of 32 vectors have arrived and keeps the data byte of the most recent message. Any unmasked vector raises an MSI-pending bit in the first-level register. Any unmasked first-level bit, or any unmasked bit of the link-event register, raises a core summary bit in the host register. The output line is high while that summary bit is set and unmasked. Software reaches all registers through a simple word-addressed write strobe and a combinational read port.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all status registers and the payload read 0 and `irq_o` is low. The first-level mask reads 0x06FFFFFF, the link-event mask reads 0x00000030, the MSI mask reads 0 and the host mask reads 0x00FEF0FB.
- R2: A pulse on `intx_asrt_i[i]` sets first-level bit 16+i, and a pulse on `intx_dasrt_i[i]` sets bit 20+i. Both are visible at the first clock edge after the pulse.
- R3: Writing a status register clears exactly the bits written as 1 and leaves the others unchanged. Only the valid field is stored: bits [26:0] of the first-level registers, bits 4 and 5 of the link-event registers, and mask 0x00FFF0FB of the host registers.
- R4: When an event and a write-1-to-clear hit the same bit in the same cycle, the bit stays set. A summary bit whose source is still pending re-sets at once after a clear.
- R5: An MSI with `msi_vld_i` high sets bit `msi_vec_i` of the MSI status register. Its `msi_data_i` is latched into bits [7:0] of the payload register, and the upper bits of that register read 0.
- R6: First-level bit 24 sets whenever an MSI vector is set whose mask bit is 0. A masked vector is still recorded but does not set bit 24.
- R7: `pm_evt_i` sets link-event bit 4 and `flush_evt_i` sets link-event bit 5.
- R8: Host bit 16 sets when any first-level or link-event bit is set with its mask bit 0. `irq_o` is high while host bit 16 is set and host mask bit 16 is 0.
- R9: Setting host mask bit 16 drops `irq_o` without clearing host bit 16. A mask register changes only when it is written.
- R10: The word address map is: 0 first-level status, 1 first-level mask, 2 link-event status, 3 link-event mask, 4 MSI status, 5 MSI mask, 6 payload, 7 host status, 8 host mask. Other addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 4 | Register word address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| intx_asrt_i | input | 4 | INTA..INTD assert message pulses |
| intx_dasrt_i | input | 4 | INTA..INTD deassert message pulses |
| msi_vld_i | input | 1 | MSI arrival pulse |
| msi_vec_i | input | 5 | MSI vector number |
| msi_data_i | input | 8 | MSI data byte |
| pm_evt_i | input | 1 | Power-state-change event pulse |
| flush_evt_i | input | 1 | Flush event pulse |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
The hardest situation to reach is an event and its own write-1-to-clear landing on the same bit in the same cycle. A close relative is clearing the MSI-pending or summary bit while its unmasked source is still set. The bench reaches the first by driving an INTx pulse and the clearing write on one negative edge, so the same rising edge captures both. It reaches the second by leaving an MSI vector set and clearing only the first-level bit. The three-stage propagation from MSI vector to the line is covered through mask combinations that stop the chain at each stage.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    // Register word addresses
    localparam logic [ADDR_W-1:0] A_L1_STAT   = 4'd0;
    localparam logic [ADDR_W-1:0] A_L1_MASK   = 4'd1;
    localparam logic [ADDR_W-1:0] A_AUX_STAT  = 4'd2;
    localparam logic [ADDR_W-1:0] A_AUX_MASK  = 4'd3;
    localparam logic [ADDR_W-1:0] A_MSI_STAT  = 4'd4;
    localparam logic [ADDR_W-1:0] A_MSI_MASK  = 4'd5;
    localparam logic [ADDR_W-1:0] A_PAYLOAD   = 4'd6;
    localparam logic [ADDR_W-1:0] A_HOST_STAT = 4'd7;
    localparam logic [ADDR_W-1:0] A_HOST_MASK = 4'd8;

    // Bit positions decoded by software
    localparam int L1_ASRT_LSB   = 16;
    localparam int L1_DASRT_LSB  = 20;
    localparam int L1_MSI_BIT    = 24;
    localparam int AUX_PM_BIT    = 4;
    localparam int AUX_FLUSH_BIT = 5;
    localparam int HOST_CORE_BIT = 16;

    // Valid fields and reset masks
    localparam logic [DATA_W-1:0] L1_VALID      = 32'h07FF_FFFF;
    localparam logic [DATA_W-1:0] L1_MASK_RST   = 32'h06FF_FFFF;
    localparam logic [DATA_W-1:0] AUX_VALID     = 32'h0000_0030;
    localparam logic [DATA_W-1:0] AUX_MASK_RST  = 32'h0000_0030;
    localparam logic [DATA_W-1:0] HOST_VALID    = 32'h00FF_F0FB;
    localparam logic [DATA_W-1:0] HOST_MASK_RST = 32'h00FE_F0FB;
endpackage

// File: rtl/irqagg_src_bank.sv
module irqagg_src_bank #(
    parameter int           W        = 32,
    parameter logic [W-1:0] VALID    = '1,
    parameter logic [W-1:0] MASK_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         stat_wr_i,
    input  logic         mask_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] pend_o,
    output logic         any_o
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (stat_wr_i) begin
            bank_d.stat = bank_q.stat & ~wdata_i;
        end
        // a new event overrides a clear of the same bit
        bank_d.stat = (bank_d.stat | set_i) & VALID;
        if (mask_wr_i) begin
            bank_d.mask = wdata_i & VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.stat <= '0;
            bank_q.mask <= MASK_RST & VALID;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign stat_o = bank_q.stat;
    assign mask_o = bank_q.mask;
    assign pend_o = bank_q.stat & ~bank_q.mask & VALID;
    assign any_o  = |pend_o;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int MSI_VECS  = 32,
    parameter int PAYLOAD_W = 8,
    parameter int INTX_N    = 4,
    localparam int VEC_W    = $clog2(MSI_VECS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [INTX_N-1:0] intx_asrt_i,
    input  logic [INTX_N-1:0] intx_dasrt_i,
    input  logic              msi_vld_i,
    input  logic [VEC_W-1:0]  msi_vec_i,
    input  logic [PAYLOAD_W-1:0] msi_data_i,
    input  logic              pm_evt_i,
    input  logic              flush_evt_i,
    output logic              irq_o
);
    typedef struct packed {
        logic [PAYLOAD_W-1:0] payload;
    } top_t;

    top_t top_d, top_q;

    logic [DATA_W-1:0]   l1_set, l1_stat, l1_mask, l1_pend;
    logic [DATA_W-1:0]   aux_set, aux_stat, aux_mask, aux_pend;
    logic [DATA_W-1:0]   host_set, host_stat, host_mask, host_pend;
    logic [MSI_VECS-1:0] msi_set, msi_stat, msi_mask, msi_pend;
    logic                l1_any, aux_any, host_any, msi_any;
    logic [PAYLOAD_W-1:0] payload_q;

    // one-hot decode of the arriving vector
    for (genvar v = 0; v < MSI_VECS; v++) begin : g_msi_dec
        assign msi_set[v] = msi_vld_i && (msi_vec_i == VEC_W'(v));
    end

    always_comb begin
        l1_set = '0;
        for (int i = 0; i < INTX_N; i++) begin
            l1_set[L1_ASRT_LSB + i]  = intx_asrt_i[i];
            l1_set[L1_DASRT_LSB + i] = intx_dasrt_i[i];
        end
        l1_set[L1_MSI_BIT] = msi_any;

        aux_set                = '0;
        aux_set[AUX_PM_BIT]    = pm_evt_i;
        aux_set[AUX_FLUSH_BIT] = flush_evt_i;

        host_set                = '0;
        host_set[HOST_CORE_BIT] = l1_any | aux_any;
    end

    irqagg_src_bank #(
        .W(MSI_VECS), .VALID('1), .MASK_RST('0)
    ) u_msi_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (msi_set),
        .stat_wr_i(reg_wr_i && reg_addr_i == A_MSI_STAT),
        .mask_wr_i(reg_wr_i && reg_addr_i == A_MSI_MASK),
        .wdata_i  (reg_wdata_i[MSI_VECS-1:0]),
        .stat_o   (msi_stat),
        .mask_o   (msi_mask),
        .pend_o   (msi_pend),
        .any_o    (msi_any)
    );

    irqagg_src_bank #(
        .W(DATA_W), .VALID(L1_VALID), .MASK_RST(L1_MASK_RST)
    ) u_l1_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (l1_set),
        .stat_wr_i(reg_wr_i && reg_addr_i == A_L1_STAT),
        .mask_wr_i(reg_wr_i && reg_addr_i == A_L1_MASK),
        .wdata_i  (reg_wdata_i),
        .stat_o   (l1_stat),
        .mask_o   (l1_mask),
        .pend_o   (l1_pend),
        .any_o    (l1_any)
    );

    irqagg_src_bank #(
        .W(DATA_W), .VALID(AUX_VALID), .MASK_RST(AUX_MASK_RST)
    ) u_aux_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (aux_set),
        .stat_wr_i(reg_wr_i && reg_addr_i == A_AUX_STAT),
        .mask_wr_i(reg_wr_i && reg_addr_i == A_AUX_MASK),
        .wdata_i  (reg_wdata_i),
        .stat_o   (aux_stat),
        .mask_o   (aux_mask),
        .pend_o   (aux_pend),
        .any_o    (aux_any)
    );

    irqagg_src_bank #(
        .W(DATA_W), .VALID(HOST_VALID), .MASK_RST(HOST_MASK_RST)
    ) u_host_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (host_set),
        .stat_wr_i(reg_wr_i && reg_addr_i == A_HOST_STAT),
        .mask_wr_i(reg_wr_i && reg_addr_i == A_HOST_MASK),
        .wdata_i  (reg_wdata_i),
        .stat_o   (host_stat),
        .mask_o   (host_mask),
        .pend_o   (host_pend),
        .any_o    (host_any)
    );

    always_comb begin
        top_d = top_q;
        if (msi_vld_i) begin
            top_d.payload = msi_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign payload_q = top_q.payload;

    always_comb begin
        case (reg_addr_i)
            A_L1_STAT:   reg_rdata_o = l1_stat;
            A_L1_MASK:   reg_rdata_o = l1_mask;
            A_AUX_STAT:  reg_rdata_o = aux_stat;
            A_AUX_MASK:  reg_rdata_o = aux_mask;
            A_MSI_STAT:  reg_rdata_o = DATA_W'(msi_stat);
            A_MSI_MASK:  reg_rdata_o = DATA_W'(msi_mask);
            A_PAYLOAD:   reg_rdata_o = DATA_W'(payload_q);
            A_HOST_STAT: reg_rdata_o = host_stat;
            A_HOST_MASK: reg_rdata_o = host_mask;
            default:     reg_rdata_o = '0;
        endcase
    end

    // level output follows the unmasked core summary bit
    assign irq_o = host_pend[HOST_CORE_BIT];

    logic unused_ok;
    assign unused_ok = ^{aux_pend, msi_pend, host_any};
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
    import irqagg_pkg::*;
#(
    parameter int MSI_VECS  = 32,
    parameter int PAYLOAD_W = 8,
    parameter int INTX_N    = 4,
    localparam int VEC_W    = $clog2(MSI_VECS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic                 reg_wr_i,
    input logic [INTX_N-1:0]    intx_asrt_i,
    input logic [INTX_N-1:0]    intx_dasrt_i,
    input logic                 msi_vld_i,
    input logic [VEC_W-1:0]     msi_vec_i,
    input logic [PAYLOAD_W-1:0] msi_data_i,
    input logic                 flush_evt_i,
    input logic [DATA_W-1:0]    l1_stat,
    input logic [DATA_W-1:0]    aux_stat,
    input logic [DATA_W-1:0]    host_stat,
    input logic [MSI_VECS-1:0]  msi_stat,
    input logic [MSI_VECS-1:0]  msi_mask,
    input logic [PAYLOAD_W-1:0] payload_q,
    input logic                 l1_any,
    input logic                 aux_any
);
    // R2
    intx_assert_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intx_asrt_i[0] |=> l1_stat[L1_ASRT_LSB]);

    // R2
    intx_deassert_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intx_dasrt_i[INTX_N-1] |=> l1_stat[L1_DASRT_LSB + INTX_N - 1]);

    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intx_asrt_i[1] |=> l1_stat[L1_ASRT_LSB + 1]);

    // R5
    msi_vector_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_vld_i |=> msi_stat[$past(msi_vec_i)]);

    // R5
    msi_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_vld_i |=> payload_q == $past(msi_data_i));

    // R7
    flush_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_evt_i |=> aux_stat[AUX_FLUSH_BIT]);

    // R8
    summary_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_stat[HOST_CORE_BIT]) |-> $past(l1_any || aux_any));

    // R9
    msi_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == A_MSI_MASK) |=> $stable(msi_mask));
endmodule

bind irq_aggregator irqagg_chk #(
    .MSI_VECS(MSI_VECS), .PAYLOAD_W(PAYLOAD_W), .INTX_N(INTX_N)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .intx_asrt_i (intx_asrt_i),
    .intx_dasrt_i(intx_dasrt_i),
    .msi_vld_i   (msi_vld_i),
    .msi_vec_i   (msi_vec_i),
    .msi_data_i  (msi_data_i),
    .flush_evt_i (flush_evt_i),
    .l1_stat     (l1_stat),
    .aux_stat    (aux_stat),
    .host_stat   (host_stat),
    .msi_stat    (msi_stat),
    .msi_mask    (msi_mask),
    .payload_q   (payload_q),
    .l1_any      (l1_any),
    .aux_any     (aux_any)
);

// File: tb/irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  intx_asrt = '0;
    logic [3:0]  intx_dasrt = '0;
    logic        msi_vld = 1'b0;
    logic [4:0]  msi_vec = '0;
    logic [7:0]  msi_data = '0;
    logic        pm_evt = 1'b0;
    logic        flush_evt = 1'b0;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .intx_asrt_i(intx_asrt), .intx_dasrt_i(intx_dasrt),
        .msi_vld_i(msi_vld), .msi_vec_i(msi_vec), .msi_data_i(msi_data),
        .pm_evt_i(pm_evt), .flush_evt_i(flush_evt),
        .irq_o(irq)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, $sformatf("reg %0d", a), v, exp);
    endtask

    task automatic irq_chk(string req, logic exp);
        @(negedge clk);
        #1 check(req, "irq_o", {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic send_msi(logic [4:0] v, logic [7:0] d);
        @(negedge clk);
        msi_vld = 1'b1; msi_vec = v; msi_data = d;
        @(negedge clk);
        msi_vld = 1'b0;
    endtask

    task automatic t_reset();
        // R1 reset values
        rd_chk("R1", 4'd0, 32'h0);
        rd_chk("R1", 4'd1, 32'h06FF_FFFF);
        rd_chk("R1", 4'd2, 32'h0);
        rd_chk("R1", 4'd3, 32'h0000_0030);
        rd_chk("R1", 4'd4, 32'h0);
        rd_chk("R1", 4'd5, 32'h0);
        rd_chk("R1", 4'd6, 32'h0);
        rd_chk("R1", 4'd7, 32'h0);
        rd_chk("R1", 4'd8, 32'h00FE_F0FB);
        irq_chk("R1", 1'b0);
    endtask

    task automatic t_intx();
        @(negedge clk); intx_asrt = 4'b0100;
        @(negedge clk); intx_asrt = '0;
        rd_chk("R2 assert INTC", 4'd0, 32'h0004_0000);
        idle(3);
        irq_chk("R8 masked source", 1'b0);
        wr(4'd1, 32'h06FF_FFFF & ~32'h0004_0000);
        idle(3);
        irq_chk("R8 unmasked source", 1'b1);
        rd_chk("R8 host bit", 4'd7, 32'h0001_0000);
        wr(4'd0, 32'h0004_0000);
        wr(4'd7, 32'h0001_0000);
        idle(2);
        irq_chk("R8 cleared", 1'b0);
        rd_chk("R3 l1 cleared", 4'd0, 32'h0);
        wr(4'd1, 32'h06FF_FFFF);
        @(negedge clk); intx_dasrt = 4'b0010;
        @(negedge clk); intx_dasrt = '0;
        rd_chk("R2 deassert INTB", 4'd0, 32'h0020_0000);
        wr(4'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_w1c();
        @(negedge clk); intx_asrt = 4'b1001;
        @(negedge clk); intx_asrt = '0;
        wr(4'd0, 32'h0001_0000);
        rd_chk("R3 partial clear", 4'd0, 32'h0008_0000);
        wr(4'd0, 32'h0008_0000);
        wr(4'd1, 32'hFFFF_FFFF);
        rd_chk("R3 mask valid field", 4'd1, 32'h07FF_FFFF);
        wr(4'd1, 32'h06FF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        rd_chk("R3 host mask valid", 4'd8, 32'h00FF_F0FB);
        wr(4'd8, 32'h00FE_F0FB);
    endtask

    task automatic t_set_wins();
        @(negedge clk); intx_asrt = 4'b0010;
        @(negedge clk); intx_asrt = '0;
        @(negedge clk);
        reg_addr = 4'd0; reg_wdata = 32'h0002_0000; reg_wr = 1'b1; intx_asrt = 4'b0010;
        @(negedge clk);
        reg_wr = 1'b0; intx_asrt = '0;
        rd_chk("R4 set beats clear", 4'd0, 32'h0002_0000);
        wr(4'd0, 32'h0002_0000);
        rd_chk("R4 later clear", 4'd0, 32'h0);
    endtask

    task automatic t_msi();
        send_msi(5'd5, 8'hA5);
        rd_chk("R5 vector", 4'd4, 32'h0000_0020);
        rd_chk("R5 payload", 4'd6, 32'h0000_00A5);
        idle(2);
        rd_chk("R6 msi pending", 4'd0, 32'h0100_0000);
        irq_chk("R8 msi irq", 1'b1);
        wr(4'd0, 32'h0100_0000);
        rd_chk("R4 pending re-sets", 4'd0, 32'h0100_0000);
        wr(4'd4, 32'h0000_0020);
        wr(4'd0, 32'h0100_0000);
        wr(4'd7, 32'h0001_0000);
        idle(2);
        irq_chk("R8 msi cleared", 1'b0);
        wr(4'd5, 32'h0000_0080);
        send_msi(5'd7, 8'h3C);
        idle(3);
        rd_chk("R6 masked vector recorded", 4'd4, 32'h0000_0080);
        rd_chk("R6 masked no pending", 4'd0, 32'h0);
        rd_chk("R5 payload masked", 4'd6, 32'h0000_003C);
        irq_chk("R6 masked no irq", 1'b0);
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd5, 32'h0);
    endtask

    task automatic t_aux();
        @(negedge clk); pm_evt = 1'b1; flush_evt = 1'b1;
        @(negedge clk); pm_evt = 1'b0; flush_evt = 1'b0;
        rd_chk("R7 link events", 4'd2, 32'h0000_0030);
        idle(2);
        irq_chk("R7 masked aux", 1'b0);
        wr(4'd3, 32'h0000_0010);
        idle(2);
        irq_chk("R8 aux irq", 1'b1);
        wr(4'd8, 32'h00FF_F0FB);
        irq_chk("R9 host mask drops irq", 1'b0);
        rd_chk("R9 host bit kept", 4'd7, 32'h0001_0000);
        wr(4'd2, 32'h0000_0030);
        wr(4'd3, 32'h0000_0030);
        wr(4'd8, 32'h00FE_F0FB);
        wr(4'd7, 32'h0001_0000);
        idle(2);
        irq_chk("R9 restored idle", 1'b0);
    endtask

    task automatic t_addr();
        wr(4'd12, 32'hFFFF_FFFF);
        rd_chk("R10 unused reads 0", 4'd12, 32'h0);
        rd_chk("R10 l1 mask untouched", 4'd1, 32'h06FF_FFFF);
        rd_chk("R10 host mask untouched", 4'd8, 32'h00FE_F0FB);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_intx();
        t_w1c();
        t_set_wins();
        t_msi();
        t_aux();
        t_addr();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5ns * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule